// File: doc/BRIEF.md
# Dual 16-Pin GPIO Port With Pull-Ups

The block holds two independent 16-pin general-purpose I/O ports, A and B, behind a small register bus. Each port has a 32-bit control register and a 16-bit data register. The control register carries a two-bit field per pin. One bit lets the processor drive the pin. The other enables a pull-up.

An external peripheral can drive the same pins through its own direction and data inputs. The block resolves each pin as a wired-OR of three terms: processor drive, peripheral drive, and a pull-up that applies only while nobody drives the pin. A read of a data register returns these resolved levels.

Every cycle the block compares the resolved levels with the previous cycle's levels. When the changed pins overlap that port's trigger mask, it emits a one-cycle change pulse together with the vector of changed pins. A system integrator wires the pins to pads and the change pulses to whatever logic needs to react to pin activity.

Top module: `gpio_dual_port`

## Requirements
- R1: After reset, all control and data registers are zero. Both pin vectors read zero while the peripheral inputs are zero, and no change pulse is asserted.
- R2: In a control register, bit 2n enables processor drive of pin n and bit 2n+1 enables the pull-up of pin n. A longword read of a control register returns the last value accepted.
- R3: The level of pin n is the OR of (processor drive AND data bit n), (peripheral direction AND peripheral data bit n), and (pull-up AND neither processor nor peripheral drives pin n). A driven low therefore beats the pull-up.
- R4: A word read of a data register returns the resolved pin levels of that port, not the value last written.
- R5: Sizes are encoded on the size input as 1 for word and 2 for longword. Data registers accept only word access and control registers only longword access. A write of the wrong size changes nothing, and a read of the wrong size returns zero.
- R6: The register offsets are 0x00 (port A control), 0x04 (port A data), 0x10 (port B control) and 0x14 (port B data). A write to any other offset changes nothing. A read of any other offset, or with the bus idle, returns zero.
- R7: A register write that changes resolved levels gives a change pulse one cycle after the write edge, when the changed-pin vector ANDed with the trigger mask is nonzero. The pulse lasts one cycle, and during it the changed-pin output carries old XOR new levels. No pulse is given when all changed pins are masked off.
- R8: Whenever the resolved levels are unchanged from one cycle to the next, no change pulse follows and the changed-pin output stays zero.
- R9: Peripheral direction and data inputs are registered every cycle. The pins reflect a new peripheral value after the next clock edge, and the matching change pulse follows one edge later.
- R10: A write to one port leaves the other port's pins and change outputs untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | 1 = word, 2 = longword |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| periDirA | input | 16 | Peripheral drive enables, port A |
| periDataA | input | 16 | Peripheral drive values, port A |
| periDirB | input | 16 | Peripheral drive enables, port B |
| periDataB | input | 16 | Peripheral drive values, port B |
| trigMaskA | input | 16 | Pins of port A that may raise a change pulse |
| trigMaskB | input | 16 | Pins of port B that may raise a change pulse |
| pinA | output | 16 | Resolved levels, port A |
| pinB | output | 16 | Resolved levels, port B |
| chgEvtA | output | 1 | Change pulse, port A |
| chgPinsA | output | 16 | Changed pins during the pulse, port A |
| chgEvtB | output | 1 | Change pulse, port B |
| chgPinsB | output | 16 | Changed pins during the pulse, port B |

## Verification
Register writes take effect on the write edge, so the pins are checked at the falling edge right after it. The change pulse is registered once more and is checked one falling edge later; the bench also confirms it has dropped at the falling edge after that. Peripheral inputs pass through one extra register. For them the bench first confirms the pins are still unchanged just after driving, then checks the new levels one edge later and the pulse one edge after that. Reads are combinational and are sampled shortly after the address is applied at a falling edge.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;

  localparam int NUM_PORTS = 2;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } accSize_e;

  // Strobes from the bus decoder to the datapath, one bit per port each.
  typedef struct packed {
    logic [NUM_PORTS-1:0] wrCtrl;
    logic [NUM_PORTS-1:0] wrData;
    logic [NUM_PORTS-1:0] rdCtrl;
    logic [NUM_PORTS-1:0] rdData;
  } gpioStb_t;

endpackage

// File: rtl/gpio_bus_ctrl.sv
module gpio_bus_ctrl
  import gpio_dual_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PORT_STRIDE = 16,
  parameter int CTRL_OFS    = 0,
  parameter int DATA_OFS    = 4
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  output gpioStb_t          stb
);

  logic isWord;
  logic isLong;

  assign isWord = (busSize == SZ_WORD);
  assign isLong = (busSize == SZ_LONG);

  logic [NUM_PORTS-1:0] hitCtrl;
  logic [NUM_PORTS-1:0] hitData;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    localparam int CTRL_ADDR = p * PORT_STRIDE + CTRL_OFS;
    localparam int DATA_ADDR = p * PORT_STRIDE + DATA_OFS;
    // Control registers are longword-only, data registers word-only.
    assign hitCtrl[p] = busSel && isLong && (busAddr == ADDR_W'(CTRL_ADDR));
    assign hitData[p] = busSel && isWord && (busAddr == ADDR_W'(DATA_ADDR));
  end

  always_comb begin
    stb        = '0;
    stb.wrCtrl = busWrite  ? hitCtrl : '0;
    stb.wrData = busWrite  ? hitData : '0;
    stb.rdCtrl = !busWrite ? hitCtrl : '0;
    stb.rdData = !busWrite ? hitData : '0;
  end

  always_comb begin
    AST_STROBE_ONEHOT: assert ($onehot0(stb)) else $error("more than one register strobe"); // R6
  end

endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice #(
  parameter int PIN_W = 16,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCtrl,
  input  logic             wrData,
  input  logic             rdCtrl,
  input  logic             rdData,
  input  logic [BUS_W-1:0] wdata,
  input  logic [PIN_W-1:0] periDirIn,
  input  logic [PIN_W-1:0] periDataIn,
  input  logic [PIN_W-1:0] trigMask,
  output logic [PIN_W-1:0] level,
  output logic             chgEvt,
  output logic [PIN_W-1:0] chgPins,
  output logic [BUS_W-1:0] portRdata
);

  localparam int CTRL_W = 2 * PIN_W;

  logic [CTRL_W-1:0] ctrlQ;
  logic [PIN_W-1:0]  dataQ;
  logic [PIN_W-1:0]  periDirQ;
  logic [PIN_W-1:0]  periDataQ;
  logic [PIN_W-1:0]  prevLevel;
  logic [PIN_W-1:0]  cpuDir;
  logic [PIN_W-1:0]  pullEn;
  logic [PIN_W-1:0]  diff;
  logic              hit;

  // Interleaved per-pin field: even bit drive enable, odd bit pull-up.
  for (genvar n = 0; n < PIN_W; n++) begin : g_field
    assign cpuDir[n] = ctrlQ[2*n];
    assign pullEn[n] = ctrlQ[2*n+1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      dataQ <= '0;
    end else begin
      if (wrCtrl) ctrlQ <= wdata[CTRL_W-1:0];
      if (wrData) dataQ <= wdata[PIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periDirQ  <= '0;
      periDataQ <= '0;
    end else begin
      periDirQ  <= periDirIn;
      periDataQ <= periDataIn;
    end
  end

  always_comb begin
    level = (cpuDir & dataQ)
          | (periDirQ & periDataQ)
          | (pullEn & ~(cpuDir | periDirQ));
  end

  assign diff = level ^ prevLevel;
  assign hit  = |(diff & trigMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= '0;
      chgEvt    <= 1'b0;
      chgPins   <= '0;
    end else begin
      prevLevel <= level;
      chgEvt    <= hit;
      chgPins   <= hit ? diff : '0;
    end
  end

  always_comb begin
    portRdata = '0;
    if (rdCtrl) portRdata = BUS_W'(ctrlQ);
    if (rdData) portRdata = BUS_W'(level);
  end

  AST_EVT_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    chgEvt |-> ((chgPins & $past(trigMask)) != '0)); // R7

  AST_NO_EVT_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (level == prevLevel) |=> (!chgEvt && chgPins == '0)); // R8

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtrl |=> $stable(ctrlQ)); // R5

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrData |=> $stable(dataQ)); // R6

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_dual_pkg::*;
#(
  parameter int PIN_W = 16,
  parameter int BUS_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  gpioStb_t                        stb,
  input  logic [BUS_W-1:0]                wdata,
  input  logic [NUM_PORTS-1:0][PIN_W-1:0] periDir,
  input  logic [NUM_PORTS-1:0][PIN_W-1:0] periData,
  input  logic [NUM_PORTS-1:0][PIN_W-1:0] trigMask,
  output logic [NUM_PORTS-1:0][PIN_W-1:0] pins,
  output logic [NUM_PORTS-1:0]            chgEvt,
  output logic [NUM_PORTS-1:0][PIN_W-1:0] chgPins,
  output logic [BUS_W-1:0]                rdata
);

  logic [NUM_PORTS-1:0][BUS_W-1:0] portRdata;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_port_slice #(
      .PIN_W(PIN_W),
      .BUS_W(BUS_W)
    ) u_slice (
      .clk       (clk),
      .rstN      (rstN),
      .wrCtrl    (stb.wrCtrl[p]),
      .wrData    (stb.wrData[p]),
      .rdCtrl    (stb.rdCtrl[p]),
      .rdData    (stb.rdData[p]),
      .wdata     (wdata),
      .periDirIn (periDir[p]),
      .periDataIn(periData[p]),
      .trigMask  (trigMask[p]),
      .level     (pins[p]),
      .chgEvt    (chgEvt[p]),
      .chgPins   (chgPins[p]),
      .portRdata (portRdata[p])
    );
  end

  // At most one slice is selected, so an OR merge is enough.
  always_comb begin
    rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) rdata |= portRdata[p];
  end

endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port
  import gpio_dual_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PIN_W  = 16,
  parameter int BUS_W  = 2 * PIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [PIN_W-1:0]  periDirA,
  input  logic [PIN_W-1:0]  periDataA,
  input  logic [PIN_W-1:0]  periDirB,
  input  logic [PIN_W-1:0]  periDataB,
  input  logic [PIN_W-1:0]  trigMaskA,
  input  logic [PIN_W-1:0]  trigMaskB,
  output logic [PIN_W-1:0]  pinA,
  output logic [PIN_W-1:0]  pinB,
  output logic              chgEvtA,
  output logic [PIN_W-1:0]  chgPinsA,
  output logic              chgEvtB,
  output logic [PIN_W-1:0]  chgPinsB
);

  gpioStb_t                        stb;
  logic [NUM_PORTS-1:0][PIN_W-1:0] pins;
  logic [NUM_PORTS-1:0]            chgEvt;
  logic [NUM_PORTS-1:0][PIN_W-1:0] chgPins;

  gpio_bus_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busSize (busSize),
    .busAddr (busAddr),
    .stb     (stb)
  );

  gpio_datapath #(
    .PIN_W(PIN_W),
    .BUS_W(BUS_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wdata   (busWdata),
    .periDir ({periDirB, periDirA}),
    .periData({periDataB, periDataA}),
    .trigMask({trigMaskB, trigMaskA}),
    .pins    (pins),
    .chgEvt  (chgEvt),
    .chgPins (chgPins),
    .rdata   (busRdata)
  );

  assign pinA     = pins[0];
  assign pinB     = pins[1];
  assign chgEvtA  = chgEvt[0];
  assign chgEvtB  = chgEvt[1];
  assign chgPinsA = chgPins[0];
  assign chgPinsB = chgPins[1];

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (busRdata == '0)); // R6

  AST_WRITE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite) |-> (busRdata == '0)); // R5

endmodule

// File: tb/gpio_dual_port_tb.sv
`timescale 1ns/1ps
module gpio_dual_port_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busSize = 2'd0;
  logic [7:0]  busAddr = 8'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic [15:0] periDirA = 16'd0, periDataA = 16'd0;
  logic [15:0] periDirB = 16'd0, periDataB = 16'd0;
  logic [15:0] trigMaskA = 16'hFFFF, trigMaskB = 16'hFFFF;
  logic [15:0] pinA, pinB, chgPinsA, chgPinsB;
  logic        chgEvtA, chgEvtB;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h00, A_DATA = 8'h04;
  localparam logic [7:0] B_CTRL = 8'h10, B_DATA = 8'h14;
  localparam logic [1:0] WORD = 2'd1, LONG = 2'd2;

  always #2.5 clk = ~clk;

  gpio_dual_port u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busSize(busSize), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .periDirA(periDirA), .periDataA(periDataA),
    .periDirB(periDirB), .periDataB(periDataB), .trigMaskA(trigMaskA),
    .trigMaskB(trigMaskB), .pinA(pinA), .pinB(pinB), .chgEvtA(chgEvtA),
    .chgPinsA(chgPinsA), .chgEvtB(chgEvtB), .chgPinsB(chgPinsB)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Write is taken at the edge after the driving negedge; returns at the next negedge.
  task automatic busWr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busSize = sz; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a; busSize = sz;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic expectEvtA(input string tag, input logic ev, input logic [15:0] chg);
    @(negedge clk);
    check({tag, " evtA"}, 32'(chgEvtA), 32'(ev));
    check({tag, " chgA"}, 32'(chgPinsA), 32'(chg));
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 pinA", 32'(pinA), 32'h0);
    check("R1 pinB", 32'(pinB), 32'h0);
    check("R1 evt", 32'({chgEvtA, chgEvtB}), 32'h0);
    busRd(A_CTRL, LONG, r); check("R1 ctrlA", r, 32'h0);
    busRd(B_DATA, WORD, r); check("R1 dataB", r, 32'h0);
  endtask

  task automatic t_pullup();
    busWr(A_CTRL, LONG, 32'h0000_0002);
    check("R2 pullup pin0", 32'(pinA), 32'h0001);
    expectEvtA("R7 pulse", 1'b1, 16'h0001);
    expectEvtA("R7 one cycle", 1'b0, 16'h0000);
  endtask

  task automatic t_cpuDrive();
    logic [31:0] r;
    busWr(A_DATA, WORD, 32'h0000_00F0);
    check("R3 undriven data", 32'(pinA), 32'h0001);
    expectEvtA("R8 no change", 1'b0, 16'h0000);
    busRd(A_DATA, WORD, r); check("R4 read levels", r, 32'h0000_0001);
    busWr(A_CTRL, LONG, 32'h0000_5502);
    check("R3 cpu drive", 32'(pinA), 32'h00F1);
    expectEvtA("R7 drive pulse", 1'b1, 16'h00F0);
    busRd(A_CTRL, LONG, r); check("R2 ctrl readback", r, 32'h0000_5502);
    busWr(A_CTRL, LONG, 32'h0000_550E);
    check("R3 low beats pullup", 32'(pinA), 32'h00F1);
    expectEvtA("R8 same levels", 1'b0, 16'h0000);
  endtask

  task automatic t_mask();
    @(negedge clk); trigMaskA = 16'h000F;
    busWr(A_DATA, WORD, 32'h0000_0070);
    check("R3 pin7 low", 32'(pinA), 32'h0071);
    expectEvtA("R7 masked off", 1'b0, 16'h0000);
    trigMaskA = 16'hFFFF;
  endtask

  task automatic t_periph();
    @(negedge clk);
    periDirA = 16'h0101; periDataA = 16'h0100;
    #1 check("R9 not yet", 32'(pinA), 32'h0071);
    @(negedge clk);
    check("R9 periph levels", 32'(pinA), 32'h0170);
    expectEvtA("R9 periph pulse", 1'b1, 16'h0101);
    periDirA = 16'h0; periDataA = 16'h0;
    @(negedge clk);
    check("R9 released", 32'(pinA), 32'h0071);
    expectEvtA("R9 release pulse", 1'b1, 16'h0101);
  endtask

  task automatic t_portB();
    busWr(B_CTRL, LONG, 32'h5555_5555);
    busWr(B_DATA, WORD, 32'h0000_A5A5);
    check("R3 pinB", 32'(pinB), 32'h0000_A5A5);
    @(negedge clk);
    check("R7 evtB", 32'(chgEvtB), 32'h1);
    check("R7 chgB", 32'(chgPinsB), 32'h0000_A5A5);
    check("R10 pinA kept", 32'(pinA), 32'h0071);
    check("R10 evtA quiet", 32'(chgEvtA), 32'h0);
  endtask

  task automatic t_size();
    logic [31:0] r;
    busWr(A_DATA, LONG, 32'h0000_FFFF);
    check("R5 long to data ignored", 32'(pinA), 32'h0071);
    busWr(A_CTRL, WORD, 32'h0000_0000);
    busRd(A_CTRL, LONG, r); check("R5 word to ctrl ignored", r, 32'h0000_550E);
    busRd(A_DATA, LONG, r); check("R5 long read data", r, 32'h0);
    busRd(A_CTRL, WORD, r); check("R5 word read ctrl", r, 32'h0);
  endtask

  task automatic t_undef();
    logic [31:0] r;
    busWr(8'h08, LONG, 32'hFFFF_FFFF);
    busWr(8'h0C, WORD, 32'h0000_FFFF);
    check("R6 pinA kept", 32'(pinA), 32'h0071);
    check("R6 pinB kept", 32'(pinB), 32'h0000_A5A5);
    busRd(8'h08, LONG, r); check("R6 read undef", r, 32'h0);
    busRd(8'h24, WORD, r); check("R6 read undef2", r, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_pullup();
    t_cpuDrive();
    t_mask();
    t_periph();
    t_portB();
    t_size();
    t_undef();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule